// File: doc/BRIEF.md
# Saturating Rounding Narrowing Vector Shifter

This block is a single-stage vector datapath. It takes two source vectors made of signed 32-bit lanes. Every lane is shifted right arithmetically by an immediate amount, rounded to nearest, and clamped into the unsigned 16-bit range. The narrowed lanes of both sources are then packed into one destination vector that is as wide as one source. The first source supplies the lower half of the result and the second source supplies the upper half.

A small decoder reads a 32-bit instruction word. It recovers the shift amount, the consecutive pair of source register numbers and the destination register number, and it flags any word that does not match the supported encoding.

The result, the decoded fields and a valid flag are registered. They appear one clock after a valid input. The vector width is a parameter, and every lane is always processed.

Top module: `nrw_shift_top`

## Requirements
- R1: Each source lane is a signed 32-bit integer taken from bits [32e+31:32e] of its source vector, and each destination lane is a 16-bit unsigned integer; the lane count per source is VLEN/32.
- R2: The shift amount is 16 minus the unsigned 4-bit immediate held in instruction bits 19..16, so it spans 1 (immediate 15) to 16 (immediate 0), and it is reported on `out_shift`.
- R3: Before the arithmetic right shift, 2^(shift-1) is added to the lane value with at least 33 bits of precision, so values at the exact half-point round upward and 0x7FFFFFFF does not wrap to a negative number.
- R4: A rounded and shifted value below zero produces a destination lane of 0.
- R5: A rounded and shifted value above 65535 produces a destination lane of 65535 (0xFFFF).
- R6: The first source register number is instruction bits 9..6 times 2, the second is that value plus 1, and the destination register number is instruction bits 4..0.
- R7: Destination lane k occupies bits [16k+15:16k]. Lane e of `src_lo` lands in destination lane e, and lane e of `src_hi` lands in destination lane VLEN/32+e.
- R8: An instruction is accepted only when bits 31..20 are 110000011111, bits 15..10 are 110101 and bit 5 is 0. For any other word, `out_undef` is 1 and `out_vec` is all zeros.
- R9: `out_valid` rises exactly one clock after a cycle with `in_valid` high, and the registered outputs reflect that cycle's inputs. After reset, `out_valid` and all outputs are 0.
- R10: In a cycle with `in_valid` low, `out_valid` is 0 on the next clock, and `out_vec`, `out_undef` and the register fields keep their previous values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| instr | input | 32 | Instruction word |
| src_lo | input | VLEN | First source vector |
| src_hi | input | VLEN | Second source vector |
| out_valid | output | 1 | Registered result valid |
| out_undef | output | 1 | Instruction word not recognised |
| out_vec | output | VLEN | Packed narrowed result |
| out_src0 | output | 5 | First source register number |
| out_src1 | output | 5 | Second source register number |
| out_dst | output | 5 | Destination register number |
| out_shift | output | 5 | Decoded shift amount |

## Verification
The bench sweeps all sixteen immediates. At each shift it applies lane values placed exactly at the rounding half-point and one below it, which separates round-up from truncation. It also applies values just at and just past the 16-bit ceiling, the signed extremes, and small negatives, which separates clamping from wrapping. Putting different values in every lane of both sources exposes any swapped or misplaced lane. Pseudo-random vectors then cover general arithmetic.

Every fixed opcode bit is flipped in turn to confirm rejection. Idle cycles with changed data confirm that the outputs hold.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
    localparam int REG_W = 5;
    localparam int SH_W  = 5;

    typedef struct packed {
        logic             ok;
        logic [SH_W-1:0]  shift;
        logic [REG_W-1:0] src0;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] dst;
    } dec_t;
endpackage

// File: rtl/nrw_decode.sv
module nrw_decode
    import nrw_pkg::*;
(
    input  logic [31:0] word_i,
    output dec_t        dec_o
);
    localparam logic [11:0] HI_PAT  = 12'b1100_0001_1111;
    localparam logic [5:0]  MID_PAT = 6'b110101;

    logic [3:0] imm4;
    logic [3:0] zn4;

    always_comb begin
        imm4        = word_i[19:16];
        zn4         = word_i[9:6];
        dec_o.ok    = (word_i[31:20] == HI_PAT) && (word_i[15:10] == MID_PAT)
                      && !word_i[5];
        // R2: shift amount is 16 minus the immediate
        dec_o.shift = 5'd16 - {1'b0, imm4};
        // R6: consecutive source pair and destination
        dec_o.src0  = {zn4, 1'b0};
        dec_o.src1  = {zn4, 1'b1};
        dec_o.dst   = word_i[4:0];
    end
endmodule

// File: rtl/nrw_lane.sv
module nrw_lane #(
    parameter int IN_W = 32,
    parameter int SH_W = 5,
    localparam int OUT_W = IN_W / 2,
    localparam int EXT_W = IN_W + 1
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic [SH_W-1:0]  sh_i,
    output logic [OUT_W-1:0] res_o
);
    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shr;

    always_comb begin
        // R3: widen by one bit so the bias cannot wrap
        ext  = $signed({val_i[IN_W-1], val_i});
        bias = $signed(EXT_W'(1) << (sh_i - SH_W'(1)));
        sum  = ext + bias;
        shr  = sum >>> sh_i;
        if (shr[EXT_W-1]) begin
            res_o = '0;                       // R4
        end else if (|shr[EXT_W-2:OUT_W]) begin
            res_o = '1;                       // R5
        end else begin
            res_o = shr[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/nrw_shift_top.sv
module nrw_shift_top
    import nrw_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int IN_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [VLEN-1:0] src_lo,
    input  logic [VLEN-1:0] src_hi,
    output logic            out_valid,
    output logic            out_undef,
    output logic [VLEN-1:0] out_vec,
    output logic [4:0]      out_src0,
    output logic [4:0]      out_src1,
    output logic [4:0]      out_dst,
    output logic [4:0]      out_shift
);
    localparam int OUT_W = IN_W / 2;
    localparam int LANES = VLEN / IN_W;

    typedef struct packed {
        logic             valid;
        logic             undef;
        logic [VLEN-1:0]  vec;
        logic [REG_W-1:0] src0;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] dst;
        logic [SH_W-1:0]  shift;
    } st_t;

    dec_t            dec;
    logic [VLEN-1:0] narrow;
    st_t             st_d, st_q;
    logic            past_ok_d, past_ok_q;

    nrw_decode u_dec (.word_i(instr), .dec_o(dec));

    // R7: first source fills low half, second fills high half
    for (genvar e = 0; e < LANES; e++) begin : g_lane
        nrw_lane #(.IN_W(IN_W), .SH_W(SH_W)) u_lo (
            .val_i(src_lo[e*IN_W +: IN_W]),
            .sh_i (dec.shift),
            .res_o(narrow[e*OUT_W +: OUT_W])
        );
        nrw_lane #(.IN_W(IN_W), .SH_W(SH_W)) u_hi (
            .val_i(src_hi[e*IN_W +: IN_W]),
            .sh_i (dec.shift),
            .res_o(narrow[(LANES+e)*OUT_W +: OUT_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        past_ok_d  = 1'b1;
        if (in_valid) begin
            st_d.undef = !dec.ok;
            st_d.vec   = dec.ok ? narrow : '0;
            st_d.src0  = dec.src0;
            st_d.src1  = dec.src1;
            st_d.dst   = dec.dst;
            st_d.shift = dec.shift;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            past_ok_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            past_ok_q <= past_ok_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_undef = st_q.undef;
    assign out_vec   = st_q.vec;
    assign out_src0  = st_q.src0;
    assign out_src1  = st_q.src1;
    assign out_dst   = st_q.dst;
    assign out_shift = st_q.shift;

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (out_valid == $past(in_valid)));
    p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_undef) |-> (out_vec == '0));
    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_src0[0] && out_src1 == out_src0 + 5'd1));
    p_shift_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_shift >= 5'd1 && out_shift <= 5'd16));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(in_valid)) |-> ($stable(out_vec) && $stable(out_undef)
                                              && $stable(out_dst)));
endmodule

// File: tb/nrw_shift_top_tb.sv
module nrw_shift_top_tb_top;
    localparam int VLEN  = 128;
    localparam int LANES = VLEN / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] src_lo = '0;
    logic [VLEN-1:0] src_hi = '0;
    logic            out_valid, out_undef;
    logic [VLEN-1:0] out_vec;
    logic [4:0]      out_src0, out_src1, out_dst, out_shift;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    nrw_shift_top #(.VLEN(VLEN)) dut_i (.*);

    function automatic logic [15:0] ref_lane(logic [31:0] x, int sh);
        longint v;
        v = longint'($signed(x)) + (longint'(1) << (sh - 1));
        v = v >>> sh;
        if (v < 0) return 16'h0000;
        if (v > 65535) return 16'hFFFF;
        return v[15:0];
    endfunction

    function automatic logic [31:0] mk_instr(logic [3:0] imm, logic [3:0] zn, logic [4:0] zd);
        return {12'b1100_0001_1111, imm, 6'b110101, zn, 1'b0, zd};
    endfunction

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check(bit ok, string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one operation, check result one cycle later
    task automatic run_op(logic [3:0] imm, logic [3:0] zn, logic [4:0] zd,
                          logic [VLEN-1:0] a, logic [VLEN-1:0] b, string req);
        logic [VLEN-1:0] exp;
        int sh;
        sh = 16 - int'(imm);
        for (int e = 0; e < LANES; e++) begin
            exp[e*16 +: 16]         = ref_lane(a[e*32 +: 32], sh);
            exp[(LANES+e)*16 +: 16] = ref_lane(b[e*32 +: 32], sh);
        end
        @(negedge clk);
        instr = mk_instr(imm, zn, zd); src_lo = a; src_hi = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1 && out_undef === 1'b0, "R9 valid", {126'd0, out_valid, out_undef}, 128'd2);
        check(out_vec === exp, req, out_vec, exp);
        check(out_shift === 5'(sh) && out_src0 === {zn, 1'b0} && out_src1 === {zn, 1'b1} && out_dst === zd,
              "R2/R6 fields", {108'd0, out_shift, out_src0, out_src1, out_dst},
              {108'd0, 5'(sh), zn, 1'b0, zn, 1'b1, zd});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] a, b, keep;
        logic [31:0] hp;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0 && out_vec === '0 && out_undef === 1'b0, "R9 reset",
              out_vec, '0);
        rst_n = 1'b1;

        for (int imm = 0; imm < 16; imm++) begin
            int sh = 16 - imm;
            hp = 32'd1 << (sh - 1);
            // R3: half-point rounding up and just below
            a = {hp - 32'd1, hp, 3 * hp, hp + (32'd1 << sh)};
            b = {-hp, -hp - 32'd1, 32'h7FFF_FFFF, 32'h8000_0000};
            run_op(4'(imm), 4'(imm), 5'(imm * 2), a, b, "R3 rounding");
            // R4/R5: ceiling and negatives
            a = {(32'd65535 << sh), (32'd65535 << sh) + hp, (32'd65535 << sh) + hp - 32'd1, 32'hFFFF_FFFF};
            b = {32'h8000_0001, 32'd0, 32'hFFFF_0000, 32'h0001_0000};
            run_op(4'(imm), 4'(15 - imm), 5'(31 - imm), a, b, "R4/R5 saturation");
            // R1/R7: distinct lanes expose placement
            for (int e = 0; e < LANES; e++) begin
                a[e*32 +: 32] = 32'((e + 1) << (sh + 1));
                b[e*32 +: 32] = 32'((e + 9) << (sh + 1));
            end
            run_op(4'(imm), 4'd3, 5'd7, a, b, "R7 lane order");
        end

        // R1: pseudo-random sweep
        for (int i = 0; i < 300; i++) begin
            for (int e = 0; e < LANES; e++) begin
                a[e*32 +: 32] = rnd() >> (i % 17);
                b[e*32 +: 32] = rnd();
            end
            run_op(4'(rnd()), 4'(rnd()), 5'(rnd()), a, b, "R1 random");
        end

        // R8: flip each fixed bit
        for (int bit_i = 5; bit_i < 32; bit_i++) begin
            if (bit_i >= 16 && bit_i <= 19) continue;
            if (bit_i >= 6 && bit_i <= 9) continue;
            @(negedge clk);
            instr = mk_instr(4'd4, 4'd1, 5'd2) ^ (32'd1 << bit_i);
            src_lo = {4{32'h0010_0000}}; src_hi = src_lo; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid === 1'b1 && out_undef === 1'b1 && out_vec === '0, "R8 reject",
                  out_vec, '0);
        end

        // R10: hold when idle
        a = {32'd100, 32'd200, 32'd300, 32'd400};
        run_op(4'd15, 4'd2, 5'd9, a, a, "R10 setup");
        keep = out_vec;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            instr = mk_instr(4'd0, 4'd7, 5'd1); src_lo = '1; src_hi = '1; in_valid = 1'b0;
            @(negedge clk);
            check(out_valid === 1'b0 && out_vec === keep && out_undef === 1'b0 && out_dst === 5'd9,
                  "R10 hold", out_vec, keep);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule